// File: doc/BRIEF.md
# Paired-Channel A/D Trigger Pulse Generator

This block couples two down-counting timer channels to time the sampling of an A/D converter. The lead channel runs continuously: it loads an interval value, counts down on each enabled tick, and at zero it pulses its interrupt, reloads, and starts again. Every lead expiry toggles a phase flag, so the lead alternates between a "down" phase and an "up" phase. The follower channel counts out a pulse width. While it runs, the trigger output is high. When its count reaches one it pulses its own interrupt, drops the trigger and stops.

The follower is re-armed only by lead expiries that occur while the lead is in its up phase. The result is one trigger pulse for every two lead intervals. One start strobe launches both channels in the same cycle. A stop input halts both and returns the trigger to its default low level. Software can read the live counts, the phase flag and the follower's running status at any time, and reading them has no effect on operation.

There is no streaming data path, so there is no valid/ready handshake and no back-pressure. All pins are plain control and status signals, and every interrupt is a single-cycle pulse.

Top module: `adc_trig_pair`

## Requirements
- R1: After reset, both counts are zero. `master_irq`, `slave_irq`, `trig_out`, `slave_running` and `master_up` are all low.
- R2: A `start` pulse (with `stop` low) loads the period into the lead count and the width into the follower count at the next edge. At that edge the follower is set running, `master_up` goes low, and `master_irq` pulses in the same cycle if and only if `start_irq_en` is high.
- R3: While the lead is enabled, its count falls by one on each edge where `tick` is high and holds where `tick` is low. On a ticked edge with the count at zero, the lead pulses `master_irq` and reloads the period, so expiries are period+1 ticks apart.
- R4: `master_up` toggles on every lead expiry.
- R5: While running, the follower count falls by one per tick. On a ticked edge with the count at 1, the follower pulses `slave_irq` for one cycle and stops with the count held at 1. The first `slave_irq` after a load comes width ticks later. The width must be nonzero.
- R6: A lead expiry that occurs while `master_up` is high (the value before the toggle) reloads the follower from the width register and sets it running. An expiry that occurs while `master_up` is low leaves the follower untouched.
- R7: `trig_out` is high exactly while the follower is running. It rises when the follower loads and falls on the cycle `slave_irq` pulses.
- R8: `stop` clears both enables and drives `trig_out` low at the next edge, with no interrupt. After that, both counts hold their values. When `start` and `stop` are high in the same cycle, `stop` takes precedence.
- R9: A period write is accepted when the lead is stopped or in its up phase. A period write made during the down phase is ignored, and the next reload uses the old value.
- R10: A width write is accepted at any time and takes effect at the follower's next load.
- R11: If an up-phase re-arm and the follower's terminal count fall on the same edge, the re-arm wins: no `slave_irq`, the count reloads, and the follower keeps running.
- R12: A `start` while running restarts both channels from their registers, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable tick |
| start | input | 1 | Start strobe for both channels |
| stop | input | 1 | Stop both channels |
| start_irq_en | input | 1 | Pulse lead interrupt at start |
| period_wr | input | 1 | Period register write enable |
| period_data | input | 16 | Period value to write |
| width_wr | input | 1 | Width register write enable |
| width_data | input | 16 | Width value to write |
| master_irq | output | 1 | Lead expiry pulse |
| slave_irq | output | 1 | Follower terminal pulse |
| trig_out | output | 1 | Trigger level to the converter |
| master_count | output | 16 | Live lead count |
| slave_count | output | 16 | Live follower count |
| slave_running | output | 1 | Follower running status |
| master_up | output | 1 | Lead phase flag (1 = up phase) |

## Verification
Several properties are checked on every cycle:
- the lead reloads and toggles its phase on each ticked expiry, and holds its count on unticked edges;
- the follower is never running in the cycle it signals its terminal count, and an idle follower keeps its count;
- a down-phase period write leaves the register unchanged;
- the trigger always equals the follower's running status;
- stop clears everything at the next edge.

Only the bench scenarios can show the end-to-end timing: the expiry spacing of period+1 ticks and the pulse spacing of width ticks for several register pairs, and the alternate-expiry re-arm pattern over two lead intervals. The bench also shows that a width written mid-run appears only at the next re-arm, and that the re-arm wins a same-edge collision with the terminal count.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  parameter int CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/trig_data_regs.sv
module trig_data_regs
  import adc_trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic period_wr,
  input  cnt_t period_data,
  input  logic width_wr,
  input  cnt_t width_data,
  input  logic lead_en,
  input  logic lead_up,
  output cnt_t period_q,
  output cnt_t width_q
);
  // Period updates only when the lead is idle or in its up phase.
  logic period_ok;
  assign period_ok = period_wr && (!lead_en || lead_up);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      width_q  <= '0;
    end else begin
      if (period_ok) period_q <= period_data;
      if (width_wr)  width_q  <= width_data;
    end
  end

  AST_PERIOD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (period_wr && lead_en && !lead_up) |=> $stable(period_q)); // R9
endmodule

// File: rtl/trig_master_chan.sv
module trig_master_chan
  import adc_trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic go,
  input  logic halt,
  input  logic go_irq_en,
  input  cnt_t period,
  output cnt_t cnt,
  output logic en,
  output logic up,
  output logic irq,
  output logic rearm
);
  logic expire;
  assign expire = en && tick && (cnt == '0) && !halt && !go;
  // Re-arm uses the phase value before this expiry flips it.
  assign rearm  = expire && up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      en  <= 1'b0;
      up  <= 1'b0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (halt) begin
        en <= 1'b0;
      end else if (go) begin
        en  <= 1'b1;
        cnt <= period;
        up  <= 1'b0;
        irq <= go_irq_en;
      end else if (en && tick) begin
        if (cnt == '0) begin
          irq <= 1'b1;
          cnt <= period;
          up  <= ~up;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_MASTER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && cnt == '0 && !halt && !go) |=> (irq && cnt == $past(period))); // R3
  AST_MASTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick && !halt && !go) |=> $stable(cnt)); // R3
  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && cnt == '0 && !halt && !go) |=> (up != $past(up))); // R4
endmodule

// File: rtl/trig_slave_chan.sv
module trig_slave_chan
  import adc_trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic go,
  input  logic halt,
  input  logic rearm,
  input  cnt_t width,
  output cnt_t cnt,
  output logic run,
  output logic irq,
  output logic trig
);
  localparam cnt_t ONE = cnt_t'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      run  <= 1'b0;
      irq  <= 1'b0;
      trig <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (halt) begin
        run  <= 1'b0;
        trig <= 1'b0;
      end else if (go || rearm) begin
        cnt  <= width;
        run  <= 1'b1;
        trig <= 1'b1;
      end else if (run && tick) begin
        if (cnt == ONE) begin
          irq  <= 1'b1;
          run  <= 1'b0;
          trig <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_SLAVE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !run); // R5
  AST_SLAVE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !go && !rearm) |=> $stable(cnt)); // R5
  AST_REARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && !halt) |=> (run && !irq)); // R11
endmodule

// File: rtl/adc_trig_pair.sv
module adc_trig_pair
  import adc_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic             start_irq_en,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_data,
  input  logic             width_wr,
  input  logic [CNT_W-1:0] width_data,
  output logic             master_irq,
  output logic             slave_irq,
  output logic             trig_out,
  output logic [CNT_W-1:0] master_count,
  output logic [CNT_W-1:0] slave_count,
  output logic             slave_running,
  output logic             master_up
);
  cnt_t period_q, width_q;
  logic lead_en, rearm, go;

  // Stop has precedence over start.
  assign go = start && !stop;

  trig_data_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .period_wr(period_wr), .period_data(period_data),
    .width_wr(width_wr), .width_data(width_data),
    .lead_en(lead_en), .lead_up(master_up),
    .period_q(period_q), .width_q(width_q)
  );

  trig_master_chan u_lead (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .halt(stop),
    .go_irq_en(start_irq_en), .period(period_q),
    .cnt(master_count), .en(lead_en), .up(master_up),
    .irq(master_irq), .rearm(rearm)
  );

  trig_slave_chan u_follow (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .halt(stop),
    .rearm(rearm), .width(width_q),
    .cnt(slave_count), .run(slave_running), .irq(slave_irq), .trig(trig_out)
  );

  AST_TRIG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out == slave_running); // R7
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!slave_running && !trig_out && !master_irq && !slave_irq)); // R8
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> (slave_running && !master_up)); // R2
endmodule

// File: tb/adc_trig_pair_test.sv
module adc_trig_pair_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tick, start, stop, start_irq_en, period_wr, width_wr;
  logic [15:0] period_data, width_data;
  logic master_irq, slave_irq, trig_out, slave_running, master_up;
  logic [15:0] master_count, slave_count;

  adc_trig_pair uut (.*);

  int errs = 0;
  int checks = 0;

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] wid;
    logic        sirq;
  } vec_t;

  localparam vec_t VEC [0:4] = '{
    '{16'd3,  16'd2, 1'b0},
    '{16'd5,  16'd5, 1'b1},
    '{16'd1,  16'd1, 1'b0},
    '{16'd10, 16'd4, 1'b1},
    '{16'd0,  16'd1, 1'b1}
  };

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic halt_all();
    stop = 1'b1; cyc(); stop = 1'b0;
  endtask

  task automatic load_regs(input int p, input int w);
    period_wr = 1'b1; period_data = 16'(p);
    width_wr = 1'b1; width_data = 16'(w);
    cyc();
    period_wr = 1'b0; width_wr = 1'b0;
  endtask

  task automatic fire();
    start = 1'b1; cyc(); start = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; start = 1'b0; stop = 1'b0; start_irq_en = 1'b0;
    period_wr = 1'b0; width_wr = 1'b0; period_data = '0; width_data = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1", "master_count", int'(master_count), 0);
    chk("R1", "slave_count", int'(slave_count), 0);
    chk("R1", "outputs", int'({master_irq, slave_irq, trig_out, slave_running, master_up}), 0);

    // Vector table: R2, R3, R5 timing
    foreach (VEC[i]) begin
      int first_m, first_s;
      halt_all();
      load_regs(int'(VEC[i].per), int'(VEC[i].wid));
      start_irq_en = VEC[i].sirq;
      fire();
      start_irq_en = 1'b0;
      first_m = -1; first_s = -1;
      chk("R2", "start master_irq", int'(master_irq), int'(VEC[i].sirq));
      chk("R2", "start master_count", int'(master_count), int'(VEC[i].per));
      chk("R2", "start slave_count", int'(slave_count), int'(VEC[i].wid));
      for (int j = 0; j <= int'(VEC[i].per) + 2; j++) begin
        if (master_irq && j > 0 && first_m < 0) first_m = j;
        if (slave_irq && first_s < 0) first_s = j;
        cyc();
      end
      chk("R3", "first expiry tick", first_m, int'(VEC[i].per) + 1);
      chk("R5", "first slave_irq tick", first_s, int'(VEC[i].wid));
    end

    // Phase, re-arm, register write rules: period 3, width 2
    halt_all();
    load_regs(3, 2);
    fire();
    for (int j = 0; j <= 13; j++) begin
      if (j == 2) begin
        chk("R5", "slave_irq at width", int'(slave_irq), 1);
        chk("R7", "trig low after slave_irq", int'(trig_out), 0);
      end
      if (j == 3) chk("R5", "slave count held at 1", int'(slave_count), 1);
      if (j == 4) begin
        chk("R3", "expiry pulse", int'(master_irq), 1);
        chk("R9", "down-phase write ignored", int'(master_count), 3);
        chk("R4", "phase up after expiry", int'(master_up), 1);
        chk("R6", "no re-arm in down phase", int'(slave_running), 0);
      end
      if (j == 8) begin
        chk("R4", "phase back down", int'(master_up), 0);
        chk("R9", "up-phase write taken", int'(master_count), 6);
        chk("R6", "re-arm in up phase", int'(slave_running), 1);
        chk("R10", "new width used", int'(slave_count), 5);
        chk("R7", "trig high on re-arm", int'(trig_out), 1);
      end
      if (j == 13) begin
        chk("R10", "slave_irq after new width", int'(slave_irq), 1);
        chk("R7", "trig low at end", int'(trig_out), 0);
      end
      if (j == 1) begin period_wr = 1'b1; period_data = 16'd9; end
      if (j == 3) begin width_wr = 1'b1; width_data = 16'd5; end
      if (j == 5) begin period_wr = 1'b1; period_data = 16'd6; end
      cyc();
      period_wr = 1'b0; width_wr = 1'b0;
    end

    // R11 collision: period 3, width 8
    halt_all();
    load_regs(3, 8);
    fire();
    for (int j = 1; j <= 8; j++) cyc();
    chk("R11", "slave_irq suppressed", int'(slave_irq), 0);
    chk("R11", "slave reloaded", int'(slave_count), 8);
    chk("R11", "slave running", int'(slave_running), 1);

    // R3 tick gating
    halt_all();
    load_regs(5, 3);
    fire();
    tick = 1'b0;
    repeat (3) cyc();
    chk("R3", "lead holds without tick", int'(master_count), 5);
    chk("R5", "follower holds without tick", int'(slave_count), 3);
    tick = 1'b1;

    // R12 restart while running
    repeat (2) cyc();
    fire();
    chk("R12", "restart lead count", int'(master_count), 5);
    chk("R12", "restart follower count", int'(slave_count), 3);

    // R8 stop
    halt_all();
    chk("R8", "stop clears running", int'(slave_running), 0);
    chk("R8", "stop trig low", int'(trig_out), 0);
    begin
      int mc, sc, seen;
      mc = int'(master_count); sc = int'(slave_count); seen = 0;
      for (int k = 0; k < 6; k++) begin
        cyc();
        if (master_irq || slave_irq) seen++;
      end
      chk("R8", "lead count frozen", int'(master_count), mc);
      chk("R8", "follower count frozen", int'(slave_count), sc);
      chk("R8", "no irq while stopped", seen, 0);
    end
    start = 1'b1; stop = 1'b1; cyc(); start = 1'b0; stop = 1'b0;
    chk("R8", "stop beats start", int'(slave_running), 0);

    finish_run();
  end
endmodule